// File: doc/BRIEF.md
# Basic-Block Code Integrity Checker

This block sits on the boundary between the fetch and decode stages of an in-order pipeline. Each instruction word that enters decode is folded into a running hash of the current basic block. When decode flags a control-transfer instruction, that block is complete. Its start address, end address and final hash are then looked up in a small associative table of expected hashes.

The block reports one of three outcomes:
- **hit**: an entry covers exactly this address range and holds the same hash.
- **mismatch**: an entry covers the range but its hash differs.
- **miss**: no valid entry covers the range.

Mismatch and miss also raise an exception line toward the operating system. Software fills the table through a write port. It can address an entry directly, or let the hardware choose the victim in round-robin order when it refills after a miss.

All work sits beside the pipeline, so the checker never stalls it. A flush abandons the block in flight without a check.

Top module: `cic_checker`

## Requirements
- R1: After reset, `res_o` is 00, `exc_o` is 0 and every table entry is invalid, so the first completed block reports a miss.
- R2: The hash accumulator starts each block at the seed 0x1F3A5C27. For each accepted word it becomes (accumulator rotated left by 5) XOR word. The block's hash is the value after its control-transfer word.
- R3: A block's start address is the PC of its first accepted word. Its end address is the PC of the word with `dec_cti_i` set. A block of a single word has equal start and end.
- R4: A valid entry with equal start, end and hash gives `res_o` = 01 with `exc_o` = 0. This appears in the cycle after the edge that follows the edge which accepted the control-transfer word.
- R5: A valid entry with equal start and end but a different hash gives `res_o` = 10 with `exc_o` = 1, with the same timing as R4.
- R6: When no valid entry matches both start and end, the block gives `res_o` = 11 with `exc_o` = 1. This covers an entry that matches only the start.
- R7: Each completed block produces exactly one result cycle. `res_o` is 00 and `exc_o` is 0 in all other cycles. Cycles with `dec_valid_i` low do not change the hash or the block.
- R8: `flush_i` discards the partial hash and the latched start address, and no result is produced for the abandoned block. A word presented in the same cycle as `flush_i` is dropped, even one with `dec_cti_i` set.
- R9: With `tbl_we_i` high and `tbl_rr_i` low, the entry at `tbl_idx_i` is written and made valid. A later write to the same index replaces it.
- R10: With `tbl_we_i` and `tbl_rr_i` high, the entry at the round-robin pointer is written. The pointer is 0 after reset and advances by one, modulo 8, after each such write. Indexed writes leave it unchanged.
- R11: When several valid entries match a block's addresses, the lowest-index entry decides the outcome.
- R12: Control-transfer words in consecutive cycles yield results in consecutive cycles, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | An instruction word enters decode this cycle |
| dec_pc_i | input | 32 | PC of that word |
| dec_word_i | input | 32 | Instruction word |
| dec_cti_i | input | 1 | Word is a control-transfer instruction (ends the block) |
| flush_i | input | 1 | Pipeline flush; abandons the current block |
| tbl_we_i | input | 1 | Table write enable |
| tbl_rr_i | input | 1 | Write to the round-robin victim instead of `tbl_idx_i` |
| tbl_idx_i | input | 3 | Entry index for indexed writes |
| tbl_start_i | input | 32 | Start address to store |
| tbl_end_i | input | 32 | End address to store |
| tbl_hash_i | input | 32 | Expected hash to store |
| res_o | output | 2 | Result: 00 none, 01 hit, 10 mismatch, 11 miss |
| exc_o | output | 1 | Exception pulse for mismatch or miss |

## Verification
The hardest case to reach from the ports is the round-robin victim position. The pointer is not visible, so the bench fills all eight slots with round-robin writes and then makes a ninth. It then shows which block now misses and which still hit.

Flush interplay is the other subtle point. The bench abandons a partly hashed block and also flushes together with a control-transfer word. A following programmed block must then hit, which proves that neither the old start address nor the old hash survived.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    RES_NONE     = 2'b00,
    RES_HIT      = 2'b01,
    RES_MISMATCH = 2'b10,
    RES_MISS     = 2'b11
  } cic_res_e;
endpackage

// File: rtl/cic_hash_unit.sv
module cic_hash_unit #(
  parameter int          AW   = 32,
  parameter int          IW   = 32,
  parameter int          ROT  = 5,
  parameter logic [IW-1:0] SEED = 32'h1F3A_5C27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [AW-1:0] dec_pc_i,
  input  logic [IW-1:0] dec_word_i,
  input  logic          dec_cti_i,
  input  logic          flush_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_start_o,
  output logic [AW-1:0] req_end_o,
  output logic [IW-1:0] req_hash_o
);
  logic          open_q;
  logic [AW-1:0] start_q;
  logic [IW-1:0] acc_q;
  logic [IW-1:0] base, folded;
  logic [AW-1:0] blk_start;
  logic          take;

  assign take      = dec_valid_i & ~flush_i;
  assign base      = open_q ? acc_q : SEED;
  assign folded    = {base[IW-1-ROT:0], base[IW-1:IW-ROT]} ^ dec_word_i;
  assign blk_start = open_q ? start_q : dec_pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      start_q <= '0;
      acc_q   <= '0;
    end else if (flush_i) begin
      open_q  <= 1'b0;
    end else if (take) begin
      open_q  <= ~dec_cti_i;
      acc_q   <= folded;
      start_q <= blk_start;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_start_o <= '0;
      req_end_o   <= '0;
      req_hash_o  <= '0;
    end else begin
      req_valid_o <= take & dec_cti_i;
      if (take & dec_cti_i) begin
        req_start_o <= blk_start;
        req_end_o   <= dec_pc_i;
        req_hash_o  <= folded;
      end
    end
  end

  assert_flush_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !req_valid_o);
  assert_req_after_cti_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(dec_valid_i && dec_cti_i && !flush_i));
endmodule

// File: rtl/cic_hash_table.sv
module cic_hash_table #(
  parameter int AW      = 32,
  parameter int IW      = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             rr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    w_start_i,
  input  logic [AW-1:0]    w_end_i,
  input  logic [IW-1:0]    w_hash_i,
  input  logic [AW-1:0]    q_start_i,
  input  logic [AW-1:0]    q_end_i,
  output logic             hit_any_o,
  output logic [IW-1:0]    hit_hash_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      start_q [ENTRIES];
  logic [AW-1:0]      end_q   [ENTRIES];
  logic [IW-1:0]      hash_q  [ENTRIES];
  logic [ENTRIES-1:0] match, wr_sel;
  logic [IDX_W-1:0]   rr_ptr_q, tgt;

  assign tgt = rr_i ? rr_ptr_q : idx_i;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign match[i]  = valid_q[i] && (start_q[i] == q_start_i) && (end_q[i] == q_end_i);
    assign wr_sel[i] = we_i && (tgt == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
        hash_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_sel[i]) begin
          valid_q[i] <= 1'b1;
          start_q[i] <= w_start_i;
          end_q[i]   <= w_end_i;
          hash_q[i]  <= w_hash_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rr_ptr_q <= '0;
    else if (we_i && rr_i)    rr_ptr_q <= (rr_ptr_q == LAST) ? '0 : rr_ptr_q + 1'b1;
  end

  // lowest index wins
  always_comb begin
    hit_any_o  = 1'b0;
    hit_hash_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_any_o  = 1'b1;
        hit_hash_o = hash_q[i];
      end
    end
  end

  assert_rr_advance_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rr_i) |=> rr_ptr_q == (($past(rr_ptr_q) == LAST) ? '0 : $past(rr_ptr_q) + 1'b1));
  assert_rr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && rr_i) |=> $stable(rr_ptr_q));
  assert_valid_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_q) >= $countones($past(valid_q)));
endmodule

// File: rtl/cic_compare.sv
module cic_compare
  import cic_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [IW-1:0] req_hash_i,
  input  logic          hit_any_i,
  input  logic [IW-1:0] hit_hash_i,
  output cic_res_e      res_o,
  output logic          exc_o
);
  cic_res_e res_d;

  always_comb begin
    if (!req_valid_i)                res_d = RES_NONE;
    else if (!hit_any_i)             res_d = RES_MISS;
    else if (hit_hash_i == req_hash_i) res_d = RES_HIT;
    else                             res_d = RES_MISMATCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= RES_NONE;
      exc_o <= 1'b0;
    end else begin
      res_o <= res_d;
      exc_o <= req_valid_i & ~(hit_any_i & (hit_hash_i == req_hash_i));
    end
  end

  assert_res_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o != RES_NONE) |-> $past(req_valid_i));
  assert_miss_no_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == RES_MISS) |-> !$past(hit_any_i));
endmodule

// File: rtl/cic_checker.sv
module cic_checker
  import cic_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          IW      = 32,
  parameter int          ENTRIES = 8,
  parameter int          ROT     = 5,
  parameter logic [IW-1:0] SEED  = 32'h1F3A_5C27,
  localparam int         IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [AW-1:0]    dec_pc_i,
  input  logic [IW-1:0]    dec_word_i,
  input  logic             dec_cti_i,
  input  logic             flush_i,
  input  logic             tbl_we_i,
  input  logic             tbl_rr_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [AW-1:0]    tbl_start_i,
  input  logic [AW-1:0]    tbl_end_i,
  input  logic [IW-1:0]    tbl_hash_i,
  output logic [1:0]       res_o,
  output logic             exc_o
);
  logic          req_valid;
  logic [AW-1:0] req_start, req_end;
  logic [IW-1:0] req_hash, hit_hash;
  logic          hit_any;
  cic_res_e      res;

  cic_hash_unit #(.AW(AW), .IW(IW), .ROT(ROT), .SEED(SEED)) u_hash (
    .clk_i, .rst_ni, .dec_valid_i, .dec_pc_i, .dec_word_i, .dec_cti_i, .flush_i,
    .req_valid_o(req_valid), .req_start_o(req_start), .req_end_o(req_end),
    .req_hash_o(req_hash)
  );

  cic_hash_table #(.AW(AW), .IW(IW), .ENTRIES(ENTRIES)) u_table (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .rr_i(tbl_rr_i), .idx_i(tbl_idx_i),
    .w_start_i(tbl_start_i), .w_end_i(tbl_end_i), .w_hash_i(tbl_hash_i),
    .q_start_i(req_start), .q_end_i(req_end),
    .hit_any_o(hit_any), .hit_hash_o(hit_hash)
  );

  cic_compare #(.IW(IW)) u_cmp (
    .clk_i, .rst_ni, .req_valid_i(req_valid), .req_hash_i(req_hash),
    .hit_any_i(hit_any), .hit_hash_i(hit_hash), .res_o(res), .exc_o(exc_o)
  );

  assign res_o = res;

  assert_exc_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> res_o[1]);
  assert_code_exc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[1] |-> exc_o);
endmodule

// File: tb/sim_cic_checker.sv
module sim_cic_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv = 1'b0, cti = 1'b0, flush = 1'b0;
  logic [31:0] pc = '0, word = '0;
  logic        we = 1'b0, rr = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] ws = '0, wend = '0, wh = '0;
  logic [1:0]  res;
  logic        exc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [31:0] SEED = 32'h1F3A_5C27;

  always #2 clk = ~clk;

  cic_checker u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv), .dec_pc_i(pc), .dec_word_i(word),
    .dec_cti_i(cti), .flush_i(flush), .tbl_we_i(we), .tbl_rr_i(rr), .tbl_idx_i(idx),
    .tbl_start_i(ws), .tbl_end_i(wend), .tbl_hash_i(wh), .res_o(res), .exc_o(exc)
  );

  function automatic logic [31:0] fold(logic [31:0] acc, logic [31:0] w);
    return {acc[26:0], acc[31:27]} ^ w;
  endfunction

  function automatic logic [31:0] wgen(logic [31:0] base, int k);
    return base ^ (32'h0101_0101 * (k + 1)) ^ (32'(k) << 7);
  endfunction

  task automatic chk(string tag, logic [1:0] er, logic ee);
    n_chk++;
    if (res !== er || exc !== ee) begin
      n_fail++;
      $display("FAIL %s: res=%b exc=%b expected res=%b exc=%b", tag, res, exc, er, ee);
    end
  endtask

  task automatic send(logic [31:0] p, logic [31:0] w, logic c);
    @(negedge clk);
    dv = 1'b1; pc = p; word = w; cti = c;
    @(negedge clk);
    dv = 1'b0; cti = 1'b0; word = 32'hDEAD_BEEF;
  endtask

  // feeds n words from start; last one ends the block; optional idle gaps
  task automatic run_block(logic [31:0] start, int n, logic [31:0] base, bit gaps,
                           output logic [31:0] h);
    h = SEED;
    for (int k = 0; k < n; k++) begin
      h = fold(h, wgen(base, k));
      send(start + 32'(4 * k), wgen(base, k), k == n - 1);
      if (gaps && k != n - 1) begin
        @(negedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic tw(bit r, logic [2:0] i, logic [31:0] s, logic [31:0] e, logic [31:0] hv);
    @(negedge clk);
    we = 1'b1; rr = r; idx = i; ws = s; wend = e; wh = hv;
    @(negedge clk);
    we = 1'b0; rr = 1'b0;
  endtask

  task automatic expect_after(string tag, logic [1:0] er, logic ee);
    @(negedge clk);
    chk(tag, er, ee);
    @(negedge clk);
    chk({tag, " R7 pulse ends"}, 2'b00, 1'b0);
  endtask

  task automatic t_reset_miss();
    logic [31:0] h;
    chk("R1 reset", 2'b00, 1'b0);
    run_block(32'h100, 3, 32'h1111_0000, 0, h);
    expect_after("R1 empty table miss", 2'b11, 1'b1);
  endtask

  task automatic t_hit_mismatch();
    logic [31:0] h, hx;
    hx = fold(fold(fold(SEED, wgen(32'h1111_0000, 0)), wgen(32'h1111_0000, 1)),
              wgen(32'h1111_0000, 2));
    tw(0, 3'd2, 32'h100, 32'h108, hx);
    run_block(32'h100, 3, 32'h1111_0000, 0, h);
    expect_after("R4 R2 R3 hit", 2'b01, 1'b0);
    run_block(32'h100, 3, 32'h1111_0001, 0, h);
    expect_after("R5 mismatch", 2'b10, 1'b1);
    run_block(32'h100, 2, 32'h1111_0000, 0, h);
    expect_after("R6 end differs miss", 2'b11, 1'b1);
    run_block(32'h100, 3, 32'h1111_0000, 1, h);
    expect_after("R7 idle gaps keep hash", 2'b01, 1'b0);
  endtask

  task automatic t_flush();
    logic [31:0] h;
    h = fold(fold(SEED, wgen(32'h2222_0000, 0)), wgen(32'h2222_0000, 1));
    tw(0, 3'd3, 32'h300, 32'h304, h);
    send(32'h200, 32'h1234_5678, 0);
    send(32'h204, 32'h9ABC_DEF0, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    @(negedge clk);
    chk("R8 flush no result", 2'b00, 1'b0);
    run_block(32'h300, 2, 32'h2222_0000, 0, h);
    expect_after("R8 fresh block after flush", 2'b01, 1'b0);
    send(32'h300, 32'h5555_5555, 0);
    @(negedge clk);
    dv = 1'b1; cti = 1'b1; pc = 32'h304; word = 32'h6666_6666; flush = 1'b1;
    @(negedge clk);
    dv = 1'b0; cti = 1'b0; flush = 1'b0;
    @(negedge clk);
    chk("R8 flush beats cti", 2'b00, 1'b0);
    @(negedge clk);
    chk("R8 flush beats cti later", 2'b00, 1'b0);
    run_block(32'h300, 2, 32'h2222_0000, 0, h);
    expect_after("R8 no stale state", 2'b01, 1'b0);
  endtask

  task automatic t_round_robin();
    logic [31:0] h;
    for (int k = 0; k < 9; k++)
      tw(1, 3'd7, 32'h1000 + 32'(k * 64), 32'h1000 + 32'(k * 64),
         fold(SEED, 32'hA000_0000 + 32'(k)));
    send(32'h1000, 32'hA000_0000, 1);
    expect_after("R10 slot0 overwritten by ninth", 2'b11, 1'b1);
    send(32'h1040, 32'hA000_0001, 1);
    expect_after("R10 R3 slot1 kept", 2'b01, 1'b0);
    send(32'h1200, 32'hA000_0008, 1);
    expect_after("R10 ninth write hits", 2'b01, 1'b0);
    send(32'h1000 + 32'(7 * 64), 32'hA000_0007, 1);
    expect_after("R10 slot7 kept", 2'b01, 1'b0);
    h = '0;
  endtask

  task automatic t_priority();
    logic [31:0] hp;
    hp = fold(SEED, 32'hBEEF_0001);
    tw(0, 3'd5, 32'h4000, 32'h4000, hp ^ 32'h1);
    tw(0, 3'd6, 32'h4000, 32'h4000, hp);
    send(32'h4000, 32'hBEEF_0001, 1);
    expect_after("R11 lowest index decides", 2'b10, 1'b0 | 1'b1);
    tw(0, 3'd5, 32'h5000, 32'h5000, 32'h0);
    send(32'h4000, 32'hBEEF_0001, 1);
    expect_after("R9 overwrite exposes idx6", 2'b01, 1'b0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    dv = 1'b1; cti = 1'b1; pc = 32'h1040; word = 32'hA000_0001;
    @(negedge clk);
    pc = 32'h1200; word = 32'hA000_0009;
    @(negedge clk);
    dv = 1'b0; cti = 1'b0;
    chk("R12 first result", 2'b01, 1'b0);
    @(negedge clk);
    chk("R12 second result", 2'b10, 1'b1);
    @(negedge clk);
    chk("R12 R7 idle after", 2'b00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_miss();
    t_hit_mismatch();
    t_flush();
    t_round_robin();
    t_priority();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule